// File: doc/BRIEF.md
# Page-Buffered Write Commit Controller

This block sits between a two-wire bus slave and a plain synchronous byte memory. It gathers the data bytes of one write sequence into a page buffer and keeps a valid flag for each byte slot. When the bus STOP arrives, it runs a self-timed commit cycle of fixed length. During that cycle it stores only the flagged bytes into memory. The block also owns the word-address counter that the slave reads. While a byte arrives, only the in-page part of that address advances, so the page row of the write stays fixed.

The slave loads a word address with `addr_ld` and then presents each received data byte with `byte_stb`. It reports the end of the sequence with `stop_stb`. While `busy` is high the slave must refuse every new access, and the block ignores all of its strobes. A write-protect input keeps every byte of the array from reaching memory.

Top module: `page_commit_ctrl`

## Requirements
- R1: Each accepted byte goes to the slot given by the counter's low 5 bits, `cur_addr[4:0]`, and then those bits increment. Slot 31 wraps to slot 0. The upper bits `cur_addr[12:5]` change only on `addr_ld`.
- R2: If more than 32 bytes arrive in one sequence, a later byte replaces the earlier byte in the same slot, and the commit stores only the last value.
- R3: A commit writes memory at `{row, slot}` only for flagged slots. The row is the page row held by the counter when the sequence's first byte arrived. Memory locations of unflagged slots, and of every other row, keep their contents.
- R4: A `stop_stb` with at least one pending byte and `wp` low raises `busy` from the next cycle. `busy` stays high for exactly `CYCLE_CLKS` cycles, with a minimum of `PAGE_BYTES`+1.
- R5: While `busy` is high, `addr_ld`, `byte_stb` and `stop_stb` have no effect. `cur_addr` holds its value, and no further commit follows.
- R6: When `wp` is high, `mem_we` is low in every cycle. A STOP that arrives with `wp` high discards the pending bytes and does not raise `busy`.
- R7: A STOP with no pending bytes, such as the one after an address-only write, raises no `busy` and writes nothing.
- R8: When `byte_stb` and `stop_stb` fall in the same cycle, that byte is part of the commit that the STOP starts.
- R9: All valid flags clear when a commit ends or a protected STOP discards the bytes. After a sequence, `cur_addr` equals the row together with the last written slot plus one (mod 32).
- R10: A commit writes at most one flagged byte per clock, in ascending slot order, within the first 32 busy cycles.
- R11: After reset, `busy`, `mem_we` and `cur_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Load the word-address counter from `addr_in` |
| addr_in | input | ADDR_W | Word address received from the bus |
| byte_stb | input | 1 | One data byte received for writing |
| byte_in | input | DATA_W | Data byte value |
| stop_stb | input | 1 | Bus STOP seen |
| wp | input | 1 | Write protect, active high |
| cur_addr | output | ADDR_W | Current word-address counter |
| busy | output | 1 | Commit cycle running; slave must reject accesses |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
Two events can fall in the same cycle: the last data byte can land in the buffer while the STOP starts the commit. The bench provokes this by raising `byte_stb` and `stop_stb` together, both in directed sequences and at random. It judges the result by checking that the final byte appears in memory and that the write count includes it. A second overlap is a rise of `wp` partway through the scan. The bench lifts `wp` after a chosen number of busy cycles and expects only the slots scanned before that point to be written.

// File: rtl/pcw_pkg.sv
`timescale 1ns/1ps
package pcw_pkg;
    localparam int unsigned PCW_ADDR_W     = 13;
    localparam int unsigned PCW_DATA_W     = 8;
    localparam int unsigned PCW_PAGE_BYTES = 32;
    // 5 ms at a 200 MHz system clock
    localparam int unsigned PCW_CYCLE_CLKS = 1_000_000;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_HOLD = 2'd2
    } pcw_phase_e;

    // The commit must outlast the buffer scan.
    function automatic int unsigned eff_cycle(int unsigned req, int unsigned page);
        return (req > page) ? req : page + 1;
    endfunction
endpackage

// File: rtl/pcw_addr_track.sv
`timescale 1ns/1ps
module pcw_addr_track #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned SLOT_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        load_addr,
    input  logic                     step,
    input  logic                     first,
    output logic [ADDR_W-1:0]        cur_addr,
    output logic [ADDR_W-SLOT_W-1:0] row
);
    localparam int unsigned ROW_W = ADDR_W - SLOT_W;

    logic [SLOT_W-1:0] slot_nxt;
    assign slot_nxt = cur_addr[SLOT_W-1:0] + SLOT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            row      <= '0;
        end else begin
            if (load)
                cur_addr <= load_addr;
            else if (step)
                cur_addr <= {cur_addr[ADDR_W-1:SLOT_W], slot_nxt};
            if (step && first)
                row <= ROW_W'(cur_addr[ADDR_W-1:SLOT_W]);
        end
    end
endmodule

// File: rtl/pcw_page_buf.sv
`timescale 1ns/1ps
module pcw_page_buf #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              any_flag
);
    logic [SLOTS-1:0]  flag_q;
    logic [DATA_W-1:0] data_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (rst)
                flag_q[s] <= 1'b0;
            else if (clr)
                flag_q[s] <= 1'b0;
            else if (hit)
                flag_q[s] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit)
                data_q[s] <= wr_data;
        end
    end

    assign rd_data  = data_q[rd_slot];
    assign rd_flag  = flag_q[rd_slot];
    assign any_flag = |flag_q;
endmodule

// File: rtl/pcw_cycle_timer.sv
`timescale 1ns/1ps
module pcw_cycle_timer #(
    parameter int unsigned EFF_CLKS = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic expire
);
    localparam int unsigned CNT_W = $clog2(EFF_CLKS + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (arm)
            cnt <= '0;
        else if (run)
            cnt <= cnt + CNT_W'(1);
    end

    assign expire = run && (cnt == CNT_W'(EFF_CLKS - 1));
endmodule

// File: rtl/pcw_commit_fsm.sv
`timescale 1ns/1ps
module pcw_commit_fsm
    import pcw_pkg::*;
#(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop,
    input  logic              pending,
    input  logic              wp,
    input  logic              expire,
    output pcw_phase_e        phase,
    output logic [SLOT_W-1:0] scan_slot,
    output logic              arm,
    output logic              clr
);
    pcw_phase_e nxt;

    always_comb begin
        nxt = phase;
        arm = 1'b0;
        clr = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (stop && pending) begin
                    if (wp) begin
                        clr = 1'b1;
                    end else begin
                        arm = 1'b1;
                        nxt = PH_SCAN;
                    end
                end
            end
            PH_SCAN: begin
                if (scan_slot == SLOT_W'(SLOTS - 1))
                    nxt = PH_HOLD;
            end
            PH_HOLD: begin
                if (expire) begin
                    clr = 1'b1;
                    nxt = PH_IDLE;
                end
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            scan_slot <= '0;
        end else begin
            phase <= nxt;
            if (phase == PH_SCAN)
                scan_slot <= scan_slot + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/page_commit_ctrl.sv
`timescale 1ns/1ps
module page_commit_ctrl
    import pcw_pkg::*;
#(
    parameter int unsigned ADDR_W     = PCW_ADDR_W,
    parameter int unsigned DATA_W     = PCW_DATA_W,
    parameter int unsigned PAGE_BYTES = PCW_PAGE_BYTES,
    parameter int unsigned CYCLE_CLKS = PCW_CYCLE_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_stb,
    input  logic              wp,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int unsigned SLOT_W   = $clog2(PAGE_BYTES);
    localparam int unsigned ROW_W    = ADDR_W - SLOT_W;
    localparam int unsigned EFF_CLKS = eff_cycle(CYCLE_CLKS, PAGE_BYTES);

    pcw_phase_e        phase;
    logic [SLOT_W-1:0] scan_slot;
    logic [ROW_W-1:0]  row;
    logic              take_byte, take_load, take_stop;
    logic              any_flag, rd_flag, arm, clr, expire;

    assign take_byte = byte_stb && !busy;
    assign take_load = addr_ld  && !busy;
    assign take_stop = stop_stb && !busy;

    pcw_addr_track #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (take_load),
        .load_addr(addr_in),
        .step     (take_byte),
        .first    (!any_flag),
        .cur_addr (cur_addr),
        .row      (row)
    );

    pcw_page_buf #(.DATA_W(DATA_W), .SLOTS(PAGE_BYTES), .SLOT_W(SLOT_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (take_byte),
        .wr_slot (cur_addr[SLOT_W-1:0]),
        .wr_data (byte_in),
        .clr     (clr),
        .rd_slot (scan_slot),
        .rd_data (mem_wdata),
        .rd_flag (rd_flag),
        .any_flag(any_flag)
    );

    pcw_commit_fsm #(.SLOTS(PAGE_BYTES), .SLOT_W(SLOT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stop     (take_stop),
        .pending  (any_flag || take_byte),
        .wp       (wp),
        .expire   (expire),
        .phase    (phase),
        .scan_slot(scan_slot),
        .arm      (arm),
        .clr      (clr)
    );

    pcw_cycle_timer #(.EFF_CLKS(EFF_CLKS)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .run   (busy),
        .expire(expire)
    );

    assign busy     = (phase != PH_IDLE);
    assign mem_we   = (phase == PH_SCAN) && rd_flag && !wp;
    assign mem_addr = {row, scan_slot};
endmodule

// File: rtl/page_commit_chk.sv
`timescale 1ns/1ps
module page_commit_chk
    import pcw_pkg::*;
#(
    parameter int unsigned ADDR_W     = PCW_ADDR_W,
    parameter int unsigned PAGE_BYTES = PCW_PAGE_BYTES,
    parameter int unsigned CYCLE_CLKS = PCW_CYCLE_CLKS
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 stop_stb,
    input logic                                 wp,
    input logic [ADDR_W-1:0]                    cur_addr,
    input logic                                 busy,
    input logic                                 mem_we,
    input logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] mem_row
);
    localparam int unsigned EFF_CLKS = eff_cycle(CYCLE_CLKS, PAGE_BYTES);
    localparam int unsigned LEN_W    = $clog2(EFF_CLKS + 2);

    logic [LEN_W-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)
            busy_len <= '0;
        else if (busy)
            busy_len <= busy_len + LEN_W'(1);
        else
            busy_len <= '0;
    end

    // R6
    wp_block_chk: assert property (@(posedge clk) disable iff (rst) wp |-> !mem_we);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_we);

    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(stop_stb));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(cur_addr));

    // R3
    row_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_row));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == LEN_W'(EFF_CLKS)));
endmodule

bind page_commit_ctrl page_commit_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .stop_stb(stop_stb),
    .wp      (wp),
    .cur_addr(cur_addr),
    .busy    (busy),
    .mem_we  (mem_we),
    .mem_row (mem_addr[ADDR_W-1:$clog2(PAGE_BYTES)])
);

// File: tb/page_commit_ctrl_test.sv
`timescale 1ns/1ps
module page_commit_ctrl_test;
    localparam int CYC = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_ld = 1'b0;
    logic [12:0] addr_in = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        stop_stb = 1'b0;
    logic        wp = 1'b0;
    logic [12:0] cur_addr;
    logic        busy;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int wp_wr = 0;
    int ord_err = 0;
    bit have_prev = 0;
    logic [4:0] prev_slot = '0;

    logic [7:0] act_mem [8192];
    logic [7:0] exp_mem [8192];

    always #2.5 clk = ~clk;

    page_commit_ctrl #(.ADDR_W(13), .DATA_W(8), .PAGE_BYTES(32), .CYCLE_CLKS(CYC)) uut (
        .clk(clk), .rst(rst), .addr_ld(addr_ld), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .stop_stb(stop_stb), .wp(wp),
        .cur_addr(cur_addr), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // memory model driven by the write port, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                act_mem[mem_addr] = mem_wdata;
                wr_cnt++;
                if (wp) wp_wr++;
                if (have_prev && mem_addr[4:0] <= prev_slot) ord_err++;
                prev_slot = mem_addr[4:0];
                have_prev = 1;
            end
            if (!busy) have_prev = 0;
        end
    end

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic run_seq(input int row, input int start, input int n, input bit wpv,
                           input bit coinc, input bit poke, input int wp_mid,
                           input string tag);
        logic [7:0] pb [32];
        bit pf [32];
        int slot, blen, exp_w, exp_len, addr_bad, mism, base;
        logic [12:0] exp_cur;
        bit commit;
        for (int s = 0; s < 32; s++) begin pf[s] = 0; pb[s] = '0; end
        row  = row % 256;
        base = row * 32;
        @(negedge clk); #1;
        wr_cnt = 0; wp_wr = 0; ord_err = 0;
        wp = wpv;
        addr_ld = 1'b1;
        addr_in = 13'(base + start % 32);
        @(negedge clk); #1;
        addr_ld = 1'b0;
        slot = start % 32;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1;
            byte_in  = 8'($urandom);
            pb[slot] = byte_in;
            pf[slot] = 1;
            slot = (slot + 1) % 32;
            stop_stb = (coinc && i == n - 1);
            @(negedge clk); #1;
        end
        byte_stb = 1'b0;
        stop_stb = 1'b0;
        if (!(coinc && n > 0)) begin
            stop_stb = 1'b1;
            @(negedge clk); #1;
            stop_stb = 1'b0;
        end
        exp_cur = 13'(base + slot);
        blen = 0;
        addr_bad = 0;
        while (busy && blen < 100000) begin
            blen++;
            if (wp_mid == blen) wp = 1'b1;
            if (poke) begin
                byte_stb = 1'b1; addr_ld = 1'b1; stop_stb = 1'b1;
                addr_in = 13'($urandom); byte_in = 8'($urandom);
                if (cur_addr != exp_cur) addr_bad++;
            end
            @(negedge clk); #1;
        end
        byte_stb = 1'b0; addr_ld = 1'b0; stop_stb = 1'b0;
        wp = wpv;
        commit  = (n > 0) && !wpv;
        exp_len = commit ? CYC : 0;
        exp_w   = 0;
        if (commit)
            for (int s = 0; s < 32; s++)
                if (pf[s] && (wp_mid <= 0 || s < wp_mid)) begin
                    exp_mem[base + s] = pb[s];
                    exp_w++;
                end
        @(negedge clk); #1;
        // R4 / R7 / R6: busy length (zero when no commit is due)
        chk(blen == exp_len, tag, "busy cycles (R4)", blen, exp_len);
        // R1 / R9: address counter after the sequence
        chk(cur_addr == exp_cur, tag, "cur_addr (R1 R9)", cur_addr, exp_cur);
        mism = 0;
        for (int s = 0; s < 32; s++)
            if (act_mem[base + s] !== exp_mem[base + s]) mism++;
        // R3: page row contents after the commit
        chk(mism == 0, tag, "page byte mismatches (R3)", mism, 0);
        // R10: one write per flagged slot, ascending
        chk(wr_cnt == exp_w && ord_err == 0, tag, "write count (R10)", wr_cnt, exp_w);
        chk(wp_wr == 0, tag, "writes under wp (R6)", wp_wr, 0);
        if (poke) begin
            // R5: strobes during busy leave counter and state alone
            chk(addr_bad == 0 && !busy, "R5", "busy-time counter drift", addr_bad, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int a = 0; a < 8192; a++) begin
            act_mem[a] = init_val(a);
            exp_mem[a] = init_val(a);
        end
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R11: reset state
        chk(busy == 0 && mem_we == 0, "R11", "busy/mem_we after reset", {busy, mem_we}, 0);
        chk(cur_addr == 0, "R11", "cur_addr after reset", cur_addr, 0);

        run_seq(5,   3,  1, 0, 0, 0, 0, "R3");   // single byte
        run_seq(9,   7,  0, 0, 0, 0, 0, "R7");   // address-only write
        run_seq(12,  0, 32, 0, 0, 0, 0, "R1");   // full page
        run_seq(20, 30, 40, 0, 0, 0, 0, "R2");   // wrap and overwrite
        run_seq(33,  4,  6, 1, 0, 0, 0, "R6");   // protected STOP
        run_seq(33, 10,  1, 0, 0, 0, 0, "R9");   // discarded flags do not return
        run_seq(41, 31,  2, 0, 1, 0, 0, "R8");   // byte and STOP together
        run_seq(41,  2,  5, 0, 0, 1, 0, "R5");   // strobes during busy
        run_seq(60,  0, 32, 0, 0, 0, 4, "R6");   // wp raised mid-scan
        run_seq(61,  0,  1, 0, 1, 0, 0, "R8");   // lone byte with STOP

        for (int t = 0; t < 40; t++)
            run_seq(int'($urandom % 256), int'($urandom % 32), int'($urandom % 41),
                    ($urandom % 5) == 0, $urandom % 2 == 1, ($urandom % 3) == 0, 0, "R3");

        begin
            int bad = 0;
            for (int a = 0; a < 8192; a++)
                if (act_mem[a] !== exp_mem[a]) bad++;
            // R3: nothing outside the committed slots changed
            chk(bad == 0, "R3", "whole-array mismatches", bad, 0);
        end
        summary();
        $finish;
    end
endmodule